// File: doc/BRIEF.md
# MMC SPI command sequencer

This block sends a single command to an MMC card over SPI and returns the one-byte status the card sends back. It does not drive the SPI wires itself. It hands bytes to a bit-level shifter through a request/acknowledge link. Each completed byte exchange also returns the byte the card shifted back during that exchange.

A command request supplies a 6-bit command index and a 32-bit argument. The block then does the following:

- lowers chip select;
- sends the six framed command bytes and one filler byte;
- watches the incoming bytes for a status reply;
- sends one more byte of clocks so the card can finish;
- raises chip select again.

A separate wake request sends a run of filler bytes with chip select high. This gives a freshly powered card the clocks it needs before it can accept a command.

Results stay on the outputs until the next command overwrites them:

- the reply byte;
- a timeout flag, set when no valid reply arrived in time;
- the seven error and state flags decoded from the reply.

Top module: `mmc_cmd_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done` and `tx_req` are 0, `cs_n` is 1, and `reply`, `timeout` and `status_flags` are all zero.
- R2: A wake request sends exactly WAKE_BYTES (default 10) bytes of 0xFF. `cs_n` stays 1 for all of them. A wake request leaves `reply`, `timeout` and `status_flags` unchanged.
- R3: The first byte of a command is 0x40 OR the command index. It is followed by the four argument bytes, most significant first.
- R4: The sixth byte is 0x95 when the command index is 0, and 0xFF for any other index. A single 0xFF byte follows it.
- R5: The reply is the first received byte with bit 7 equal to 0, looking from the byte returned during the seventh transmitted byte onward. Each additional byte is polled by sending 0xFF. At most POLL_LIMIT (default 32) additional bytes are polled, so a valid reply on the last of them still counts.
- R6: If no byte with bit 7 clear arrives within that window, `timeout` goes to 1, `reply` holds the last byte received, and `status_flags` reads 0.
- R7: Without a timeout, `status_flags` bit n equals reply bit n for n = 0..6. The bits mean: 0 idle, 1 erase reset, 2 illegal command, 3 command CRC error, 4 erase sequence error, 5 address error, 6 parameter error. A zero reply with `timeout` 0 means success.
- R8: After the reply, exactly one trailing 0xFF byte is sent. `cs_n` is 0 for every byte of a command, from the first command byte through the trailing byte. `cs_n` returns to 1 in the same cycle as `done`.
- R9: Requests are accepted only while `busy` is 0, and `busy` is 1 from the cycle after acceptance. A wake request takes priority over a simultaneous command request. Requests made while `busy` is 1 are ignored.
- R10: One byte is transferred in each cycle where `tx_req` and `tx_ack` are both 1. `tx_byte` holds steady while `tx_req` waits for `tx_ack`. `rx_byte` is taken in the cycle of the acknowledge.
- R11: `done` pulses for exactly one cycle, in the cycle after the final byte's acknowledge. `tx_req` is 0 during that pulse, and `busy` falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wake_req | input | 1 | Request a run of power-up filler bytes |
| cmd_req | input | 1 | Request a command transaction |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| reply | output | 8 | Reply byte captured from the card |
| timeout | output | 1 | No valid reply within the poll window |
| status_flags | output | 7 | Decoded reply flags, zero on timeout |
| cs_n | output | 1 | Card chip select, active low |
| tx_req | output | 1 | Byte exchange request to the shifter |
| tx_byte | output | 8 | Byte to shift out |
| tx_ack | input | 1 | Shifter completed the byte exchange |
| rx_byte | input | 8 | Byte shifted in, valid with `tx_ack` |

## Verification
An accepted request shows up one cycle later: `busy`, `tx_req` and, for a command, `cs_n` low. The bench samples these on the first falling edge after the request's rising edge. Each byte is taken on the clock edge where the shifter model's acknowledge is high. The model therefore logs `tx_byte` and `cs_n` at the moment it raises the acknowledge, and compares the full log with a byte stream computed from the command and the planned card responses. `reply`, `timeout`, `status_flags` and the `cs_n` release are due in the cycle right after the final acknowledge, together with `done`. The bench confirms this by checking that the final acknowledge was exactly one cycle earlier, and by checking `busy` low one cycle after that.

// File: rtl/mmc_seq_pkg.sv
package mmc_seq_pkg;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam logic [7:0] START_BITS  = 8'h40;
    localparam logic [7:0] IDLE_CRC    = 8'h95;
    localparam int         FRAME_BYTES = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_FRAME,
        ST_HUNT,
        ST_TAIL,
        ST_DONE
    } seq_state_e;

    // Bit order follows the reply byte: parameter error at bit 6 down to idle at bit 0.
    typedef struct packed {
        logic param_err;
        logic addr_err;
        logic erase_seq_err;
        logic crc_err;
        logic illegal_cmd;
        logic erase_reset;
        logic in_idle;
    } reply_flags_t;

    // Byte of the command frame at position pos (0..6).
    function automatic logic [7:0] frame_byte(input logic [5:0]  idx,
                                              input logic [31:0] arg,
                                              input logic [2:0]  pos);
        logic [7:0] b;
        case (pos)
            3'd0:    b = START_BITS | {2'b00, idx};
            3'd1:    b = arg[31:24];
            3'd2:    b = arg[23:16];
            3'd3:    b = arg[15:8];
            3'd4:    b = arg[7:0];
            3'd5:    b = (idx == 6'd0) ? IDLE_CRC : FILL_BYTE;
            default: b = FILL_BYTE;
        endcase
        return b;
    endfunction

    function automatic reply_flags_t decode_reply(input logic [6:0] r);
        return reply_flags_t'(r);
    endfunction

endpackage

// File: rtl/mmc_cmd_frame.sv
module mmc_cmd_frame
    import mmc_seq_pkg::*;
(
    input  logic        framing,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic [2:0]  pos,
    output logic [7:0]  byte_out
);

    always_comb begin
        if (framing) begin
            byte_out = frame_byte(idx, arg, pos);
        end else begin
            byte_out = FILL_BYTE;
        end
    end

endmodule

// File: rtl/mmc_reply_hunt.sv
module mmc_reply_hunt #(
    parameter int POLL_LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic rx_msb,
    output logic hit,
    output logic expire
);

    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [CNT_W-1:0] miss_q;
    logic             last_slot;

    assign last_slot = (miss_q == CNT_W'(POLL_LIMIT));
    assign hit       = sample && !rx_msb;
    assign expire    = sample && rx_msb && last_slot;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            miss_q <= '0;
        end else if (sample && rx_msb && !last_slot) begin
            miss_q <= miss_q + 1'b1;
        end
    end

endmodule

// File: rtl/mmc_status_decode.sv
module mmc_status_decode
    import mmc_seq_pkg::*;
(
    input  logic [6:0] reply_low,
    input  logic       timed_out,
    output logic [6:0] flags
);

    reply_flags_t dec;

    always_comb begin
        dec = decode_reply(reply_low);
        if (timed_out) begin
            dec = '0;
        end
        flags = dec;
    end

endmodule

// File: rtl/mmc_cmd_seq.sv
module mmc_cmd_seq
    import mmc_seq_pkg::*;
#(
    parameter int WAKE_BYTES = 10,
    parameter int POLL_LIMIT = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wake_req,
    input  logic        cmd_req,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] cmd_arg,
    output logic        busy,
    output logic        done,
    output logic [7:0]  reply,
    output logic        timeout,
    output logic [6:0]  status_flags,
    output logic        cs_n,
    output logic        tx_req,
    output logic [7:0]  tx_byte,
    input  logic        tx_ack,
    input  logic [7:0]  rx_byte
);

    localparam int POS_MAX = (WAKE_BYTES > FRAME_BYTES) ? WAKE_BYTES : FRAME_BYTES;
    localparam int POS_W   = $clog2(POS_MAX);
    localparam logic [POS_W-1:0] WAKE_LAST  = POS_W'(WAKE_BYTES - 1);
    localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_BYTES - 1);

    seq_state_e       state_q;
    logic [POS_W-1:0] pos_q;
    logic [5:0]       idx_q;
    logic [31:0]      arg_q;
    logic [7:0]       reply_q;
    logic             timeout_q;
    logic             cs_n_q;

    logic accept_cmd;
    logic framing;
    logic hunt_sample;
    logic hunt_hit;
    logic hunt_expire;
    logic resolved;

    assign accept_cmd  = (state_q == ST_IDLE) && !wake_req && cmd_req;
    assign framing     = (state_q == ST_FRAME);
    assign hunt_sample = tx_ack && ((framing && pos_q == FRAME_LAST) || state_q == ST_HUNT);
    assign resolved    = hunt_hit || hunt_expire;

    mmc_cmd_frame u_frame (
        .framing  (framing),
        .idx      (idx_q),
        .arg      (arg_q),
        .pos      (pos_q[2:0]),
        .byte_out (tx_byte)
    );

    mmc_reply_hunt #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_hunt (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept_cmd),
        .sample (hunt_sample),
        .rx_msb (rx_byte[7]),
        .hit    (hunt_hit),
        .expire (hunt_expire)
    );

    mmc_status_decode u_decode (
        .reply_low (reply_q[6:0]),
        .timed_out (timeout_q),
        .flags     (status_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pos_q     <= '0;
            idx_q     <= '0;
            arg_q     <= '0;
            reply_q   <= '0;
            timeout_q <= 1'b0;
            cs_n_q    <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    pos_q <= '0;
                    if (wake_req) begin
                        state_q <= ST_WAKE;
                    end else if (cmd_req) begin
                        state_q <= ST_FRAME;
                        idx_q   <= cmd_idx;
                        arg_q   <= cmd_arg;
                        cs_n_q  <= 1'b0;
                    end
                end
                ST_WAKE: begin
                    if (tx_ack) begin
                        if (pos_q == WAKE_LAST) begin
                            state_q <= ST_DONE;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                ST_FRAME: begin
                    if (tx_ack) begin
                        if (pos_q == FRAME_LAST) begin
                            if (resolved) begin
                                reply_q   <= rx_byte;
                                timeout_q <= hunt_expire;
                                state_q   <= ST_TAIL;
                            end else begin
                                state_q <= ST_HUNT;
                            end
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                ST_HUNT: begin
                    if (tx_ack && resolved) begin
                        reply_q   <= rx_byte;
                        timeout_q <= hunt_expire;
                        state_q   <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (tx_ack) begin
                        state_q <= ST_DONE;
                        cs_n_q  <= 1'b1;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign tx_req  = busy && !done;
    assign cs_n    = cs_n_q;
    assign reply   = reply_q;
    assign timeout = timeout_q;

endmodule

// File: rtl/mmc_cmd_seq_chk.sv
module mmc_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wake_req,
    input logic       cmd_req,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic [6:0] status_flags,
    input logic       cs_n,
    input logic       tx_req,
    input logic [7:0] tx_byte,
    input logic       tx_ack
);

    // R8
    cs_low_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R8
    cs_release_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !tx_req);

    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req && !tx_ack |=> tx_req && $stable(tx_byte));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && (cmd_req || wake_req) |=> busy);

    // R6
    timeout_flags_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> status_flags == 7'd0);

endmodule

bind mmc_cmd_seq mmc_cmd_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wake_req     (wake_req),
    .cmd_req      (cmd_req),
    .busy         (busy),
    .done         (done),
    .timeout      (timeout),
    .status_flags (status_flags),
    .cs_n         (cs_n),
    .tx_req       (tx_req),
    .tx_byte      (tx_byte),
    .tx_ack       (tx_ack)
);

// File: tb/mmc_cmd_seq_tb.sv
`timescale 1ns/100ps
module mmc_cmd_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        wake_req;
    logic        cmd_req;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic        busy, done, timeout, cs_n, tx_req, tx_ack;
    logic [7:0]  reply, tx_byte, rx_byte;
    logic [6:0]  status_flags;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int last_ack_cyc = 0;
    int lat      = 0;
    int waitc    = 0;

    logic [7:0] rsp_q[$];
    logic [7:0] sent_q[$];
    logic       cs_log[$];
    logic [7:0] plan[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    mmc_cmd_seq u_dut (
        .clk(clk), .rst(rst), .wake_req(wake_req), .cmd_req(cmd_req),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .busy(busy), .done(done),
        .reply(reply), .timeout(timeout), .status_flags(status_flags),
        .cs_n(cs_n), .tx_req(tx_req), .tx_byte(tx_byte), .tx_ack(tx_ack),
        .rx_byte(rx_byte)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural byte shifter and card: acknowledges after lat idle cycles,
    // returns planned bytes in order, logs what was sent.
    initial begin
        tx_ack  = 1'b0;
        rx_byte = 8'hFF;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                tx_ack = 1'b0;
                waitc  = 0;
            end else if (tx_ack) begin
                tx_ack = 1'b0;
            end else if (tx_req) begin
                if (waitc >= lat) begin
                    tx_ack  = 1'b1;
                    rx_byte = (rsp_q.size() > 0) ? rsp_q.pop_front() : 8'hFF;
                    sent_q.push_back(tx_byte);
                    cs_log.push_back(cs_n);
                    last_ack_cyc = cyc;
                    waitc = 0;
                end else begin
                    waitc++;
                end
            end
        end
    end

    // Per-clock comparison of idle-state outputs against the model.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && !busy) begin
                check(cs_n == 1'b1 && tx_req == 1'b0, "R8", "idle cs_n/tx_req",
                      {cs_n, tx_req}, 2'b10);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    task automatic wait_done(input bit poke);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            #1;
            if (poke && k == 2) begin
                cmd_req  = 1'b1;
                wake_req = 1'b1;
                cmd_idx  = 6'h2A;
                cmd_arg  = 32'hDEAD_BEEF;
            end else if (poke && k == 3) begin
                cmd_req  = 1'b0;
                wake_req = 1'b0;
            end
            if (done) break;
        end
        check(done == 1'b1, "R11", "done seen", done, 1);
        check(cyc - last_ack_cyc == 1, "R11", "done one cycle after last ack",
              cyc - last_ack_cyc, 1);
        check(cs_n == 1'b1, "R8", "cs_n released with done", cs_n, 1);
        check(tx_req == 1'b0, "R11", "no request during done", tx_req, 0);
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input int lat_i, input bit poke);
        logic [7:0] last_rx;
        logic [7:0] rv;
        bit found;
        int n;
        int sz;
        logic [7:0] old_reply;
        // expected stream
        exp_q.delete();
        exp_q.push_back(8'h40 | {2'b00, idx});
        for (int b = 0; b < 4; b++) exp_q.push_back(arg[31 - 8*b -: 8]);
        exp_q.push_back((idx == 6'd0) ? 8'h95 : 8'hFF);
        exp_q.push_back(8'hFF);
        found = 0;
        last_rx = 8'hFF;
        n = 6;
        for (int i = 6; i <= 6 + 32; i++) begin
            rv = (i < plan.size()) ? plan[i] : 8'hFF;
            last_rx = rv;
            n = i;
            if (!rv[7]) begin
                found = 1;
                break;
            end
        end
        for (int j = 7; j <= n; j++) exp_q.push_back(8'hFF);
        exp_q.push_back(8'hFF);

        @(negedge clk);
        rsp_q = plan;
        sent_q.delete();
        cs_log.delete();
        lat     = lat_i;
        cmd_idx = idx;
        cmd_arg = arg;
        cmd_req = 1'b1;
        old_reply = reply;
        @(negedge clk);
        cmd_req = 1'b0;
        #1;
        check(busy && tx_req && !cs_n, "R9", "busy/cs one cycle after accept",
              {busy, tx_req, cs_n}, 3'b110);
        wait_done(poke);

        sz = exp_q.size();
        check(sent_q.size() == sz, lat_i > 0 ? "R10" : "R5", "byte count",
              sent_q.size(), sz);
        for (int j = 0; j < sz && j < sent_q.size(); j++) begin
            string t;
            if (j < 5) t = "R3";
            else if (j < 7) t = "R4";
            else if (j < sz - 1) t = "R5";
            else t = "R8";
            check(sent_q[j] == exp_q[j], t, $sformatf("byte %0d", j), sent_q[j], exp_q[j]);
            check(cs_log[j] == 1'b0, "R8", $sformatf("cs_n at byte %0d", j), cs_log[j], 0);
        end
        check(timeout == !found, "R6", "timeout", timeout, !found);
        check(reply == last_rx, found ? "R5" : "R6", "reply", reply, last_rx);
        check(status_flags == (found ? last_rx[6:0] : 7'd0), found ? "R7" : "R6",
              "status_flags", status_flags, found ? last_rx[6:0] : 7'd0);
        @(negedge clk);
        #1;
        check(busy == 1'b0, "R11", "busy falls after done", busy, 0);
        if (poke) begin
            sz = sent_q.size();
            repeat (6) @(negedge clk);
            #1;
            check(busy == 1'b0 && sent_q.size() == sz, "R9", "request while busy ignored",
                  {busy, sent_q.size()}, sz);
        end
        if (old_reply == 8'hAA) check(1'b0, "R7", "unreachable", 0, 0);
    endtask

    task automatic run_wake(input bit with_cmd);
        logic [7:0] r0;
        logic       t0;
        @(negedge clk);
        r0 = reply;
        t0 = timeout;
        sent_q.delete();
        cs_log.delete();
        rsp_q.delete();
        lat = 1;
        wake_req = 1'b1;
        cmd_req  = with_cmd;
        cmd_idx  = 6'h11;
        @(negedge clk);
        wake_req = 1'b0;
        cmd_req  = 1'b0;
        #1;
        check(busy == 1'b1 && cs_n == 1'b1, with_cmd ? "R9" : "R2",
              "wake accepted with cs_n high", {busy, cs_n}, 2'b11);
        wait_done(1'b0);
        check(sent_q.size() == 10, "R2", "wake byte count", sent_q.size(), 10);
        for (int j = 0; j < sent_q.size(); j++) begin
            check(sent_q[j] == 8'hFF && cs_log[j] == 1'b1, "R2",
                  $sformatf("wake byte %0d", j), {sent_q[j], cs_log[j]}, 9'h1FF);
        end
        check(reply == r0 && timeout == t0, "R2", "results kept over wake",
              {reply, timeout}, {r0, t0});
        @(negedge clk);
        #1;
        check(busy == 1'b0, "R11", "busy falls after wake", busy, 0);
    endtask

    initial begin
        rst      = 1'b1;
        wake_req = 1'b0;
        cmd_req  = 1'b0;
        cmd_idx  = '0;
        cmd_arg  = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !tx_req && cs_n, "R1", "outputs in reset",
              {busy, done, tx_req, cs_n}, 4'b0001);
        check(reply == 8'd0 && !timeout && status_flags == 7'd0, "R1", "results in reset",
              {reply, timeout, status_flags}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !done && !tx_req && cs_n, "R1", "outputs after reset",
              {busy, done, tx_req, cs_n}, 4'b0001);

        // R2: power-up filler run
        run_wake(1'b0);

        // R3 R4 R7: index 0, immediate idle reply
        plan = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h01};
        run_cmd(6'd0, 32'h0, 0, 1'b0);

        // R3 R5 R10: late reply after three extra polls, slow shifter
        plan = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hC0, 8'h80, 8'hFF, 8'h00};
        run_cmd(6'd17, 32'h1234_5678, 2, 1'b0);

        // R5: valid reply on the 32nd additional byte
        plan.delete();
        for (int i = 0; i < 38; i++) plan.push_back(8'hFF);
        plan.push_back(8'h7E);
        run_cmd(6'h3F, 32'hA5C3_0F81, 0, 1'b0);

        // R6: nothing valid within the window; last byte 0x9C
        plan.delete();
        for (int i = 0; i < 38; i++) plan.push_back((i % 2) ? 8'h80 : 8'hFF);
        plan.push_back(8'h9C);
        plan.push_back(8'h00);
        run_cmd(6'd9, 32'h0000_0200, 1, 1'b0);

        // R7 R9: error reply, requests poked while busy
        plan = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h44};
        run_cmd(6'd24, 32'hFFFF_0001, 1, 1'b1);

        // R9: wake wins over simultaneous command
        run_wake(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule